// File: doc/BRIEF.md
# Edge-Selectable Input Capture Channel

One channel of a multi-channel timer. It records when a chosen transition occurs on an external pin. The counter is shared by all channels and lives outside the block. The channel passes the pin through a synchronizer and tracks the pin's settled level in a two-state machine. When the transition matches the selected edge mode, it latches the counter into a capture register. That register is presented as a high byte and a low byte. The capture also sets a status flag, and the flag drives an interrupt request when the request is enabled.

The edge detector has two states: `LVL_LOW` and `LVL_HIGH`, which track the last synchronized pin level. The transition `LVL_LOW`→`LVL_HIGH` is a rise, and `LVL_HIGH`→`LVL_LOW` is a fall. Every other case stays in the current state. The state is tracked even while capture is disabled, so enabling a mode later never produces a false edge. The synchronizer and the capture register together give a latched count that is exactly two above the count in the clock cycle where the pin changed.

Top module: `icap_channel`

## Requirements
- R1: After reset the capture value is 0, the flag is 0 and the interrupt request is 0.
- R2: With edge mode 2'b01, a low-to-high pin transition captures, and a high-to-low transition does not.
- R3: With edge mode 2'b10, a high-to-low pin transition captures, and a low-to-high transition does not.
- R4: With edge mode 2'b11, both pin transitions capture.
- R5: With edge mode 2'b00, pin transitions leave the value and the flag unchanged, and switching to another mode afterwards does not create a capture from an earlier transition.
- R6: A capture updates the value and flag at the third rising clock edge after the pin change. The value is the counter input from the clock cycle in which the pin changed, plus two, modulo 2^16, for a counter that advances by one per cycle.
- R7: `cap_hi_o` carries bits 15:8 of the captured value and `cap_lo_o` carries bits 7:0.
- R8: A capture sets the flag. The flag stays set until a cycle with `flag_clr_i` high and no capture, after which it reads 0.
- R9: If a capture and `flag_clr_i` fall on the same clock edge, the flag stays set.
- R10: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.
- R11: A new capture overwrites the value even if the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Shared timer counter value |
| pin_i | input | 1 | Asynchronous external capture pin |
| edge_sel_i | input | 2 | Edge mode: 00 off, 01 rise, 10 fall, 11 both |
| irq_en_i | input | 1 | Interrupt request enable |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cap_hi_o | output | 8 | Captured value, upper byte |
| cap_lo_o | output | 8 | Captured value, lower byte |
| flag_o | output | 1 | Capture status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with its defaults: a 16-bit counter and a two-stage synchronizer. Under these settings the plus-two latency rule holds exactly, so every expected capture can be derived from the count sampled when the pin changes. The bench counter starts just below its top value, which puts the earliest captures across the wrap from 16'hFFFF to 0 and across carries from the low byte into the high byte.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o
);
    logic [STAGES-1:0] ff_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[s] <= 1'b0;
                else        ff_q[s] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[s] <= 1'b0;
                else        ff_q[s] <= ff_q[s-1];
            end
        end
    end

    assign lvl_o = ff_q[STAGES-1];
endmodule

// File: rtl/icap_edge_fsm.sv
module icap_edge_fsm
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  edge_mode_t mode_i,
    output logic       stb_o
);
    lvl_state_t state_q, state_d;
    logic rise, fall;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // Next state: follow the settled level whatever the mode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) state_d = LVL_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = lvl_i;
            LVL_HIGH: fall = !lvl_i;
        endcase
        unique case (mode_i)
            EDGE_OFF:  stb_o = 1'b0;
            EDGE_RISE: stb_o = rise;
            EDGE_FALL: stb_o = fall;
            EDGE_BOTH: stb_o = rise | fall;
        endcase
    end

    // R2: a strobe is always accompanied by a change of tracked level
    p_stb_moves_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> state_q != $past(state_q))
        else $error("strobe without level change");
endmodule

// File: rtl/icap_latch.sv
module icap_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic [W-1:0] cnt_i,
    input  logic         clr_i,
    output logic [W-1:0] val_q,
    output logic         flag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (stb_i) val_q <= cnt_i;
            if (stb_i)      flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> val_q == $past(cnt_i))
        else $error("capture value wrong");
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(val_q))
        else $error("value moved without capture");
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !stb_i) |=> !flag_q)
        else $error("flag not cleared");
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> flag_q)
        else $error("capture lost its flag");
endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               pin_i,
    input  logic [1:0]         edge_sel_i,
    input  logic               irq_en_i,
    input  logic               flag_clr_i,
    output logic [CNT_W/2-1:0] cap_hi_o,
    output logic [CNT_W/2-1:0] cap_lo_o,
    output logic               flag_o,
    output logic               irq_o
);
    localparam int HALF_W = CNT_W / 2;

    logic             lvl;
    logic             cap_stb;
    logic [CNT_W-1:0] cap_val;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .lvl_o (lvl)
    );

    icap_edge_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .mode_i (edge_mode_t'(edge_sel_i)),
        .stb_o  (cap_stb)
    );

    icap_latch #(.W(CNT_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (cap_stb),
        .cnt_i  (cnt_i),
        .clr_i  (flag_clr_i),
        .val_q  (cap_val),
        .flag_q (flag_o)
    );

    assign cap_hi_o = cap_val[CNT_W-1:HALF_W];
    assign cap_lo_o = cap_val[HALF_W-1:0];
    assign irq_o    = flag_o & irq_en_i;

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'b00) |=> $stable({cap_hi_o, cap_lo_o}))
        else $error("capture while disabled");
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> irq_en_i)
        else $error("request without enable");
endmodule

// File: tb/tb_icap_channel.sv
`timescale 1ns/1ps
module tb_icap_channel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt;
    logic        pin;
    logic [1:0]  sel;
    logic        en, clr;
    logic [7:0]  hi, lo;
    logic        flag, irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= 16'hFFF0;
        else        cnt <= cnt + 16'd1;
    end

    icap_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin),
        .edge_sel_i(sel), .irq_en_i(en), .flag_clr_i(clr),
        .cap_hi_o(hi), .cap_lo_o(lo), .flag_o(flag), .irq_o(irq)
    );

    // {mode[1:0], pin level, capture expected}
    localparam logic [3:0] VEC [12] = '{
        4'b0111, 4'b0100, 4'b1010, 4'b1001, 4'b1111, 4'b1101,
        4'b0010, 4'b0000, 4'b0100, 4'b0111, 4'b1110, 4'b1101
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [15:0] c, prev, expv;
        rst_n = 1'b0; pin = 1'b0; sel = 2'b00; en = 1'b0; clr = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 value", {hi, lo}, 16'h0000);
        check("R1 flag", flag, 1'b0);
        check("R1 irq", irq, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            logic [3:0] v;
            v = VEC[i];
            sel = v[3:2];
            clear_flag();
            prev = {hi, lo};
            c = cnt;
            pin = v[1];
            repeat (3) @(posedge clk);
            @(negedge clk);
            expv = v[0] ? c + 16'd2 : prev;
            check({tag_of(v[3:2]), "/R6 value"}, {hi, lo}, expv);
            check({tag_of(v[3:2]), "/R8 flag"}, flag, v[0]);
        end

        // R6 exact latency, R7 halves
        sel = 2'b11;
        clear_flag();
        c = cnt;
        pin = ~pin;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R6 not early", flag, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expv = c + 16'd2;
        check("R6 flag", flag, 1'b1);
        check("R7 hi", hi, expv[15:8]);
        check("R7 lo", lo, expv[7:0]);

        // R8 flag holds
        repeat (5) @(negedge clk);
        check("R8 hold", flag, 1'b1);

        // R10 request gating
        check("R10 disabled", irq, 1'b0);
        en = 1'b1; #1;
        check("R10 enabled", irq, 1'b1);

        // R11 overwrite while flag set
        @(negedge clk);
        c = cnt;
        pin = ~pin;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 value", {hi, lo}, c + 16'd2);
        check("R11 flag", flag, 1'b1);

        // R9 capture and clear on the same edge
        c = cnt;
        pin = ~pin;
        repeat (2) @(posedge clk);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R9 flag", flag, 1'b1);
        check("R9 value", {hi, lo}, c + 16'd2);

        // R8 plain clear
        clear_flag();
        check("R8 cleared", flag, 1'b0);
        check("R10 cleared", irq, 1'b0);

        // R5 transitions while off do not leak into a later mode
        sel = 2'b00;
        prev = {hi, lo};
        pin = 1'b0;
        repeat (4) @(negedge clk);
        pin = 1'b1;
        repeat (4) @(negedge clk);
        sel = 2'b01;
        repeat (4) @(negedge clk);
        check("R5 no late flag", flag, 1'b0);
        check("R5 value kept", {hi, lo}, prev);

        finish_up();
    end
endmodule